// File: doc/BRIEF.md
# Registered Arithmetic, Logic and Shift Unit

This block applies one operation per clock edge to two operand words, `a` and `b`. The operation may be arithmetic, bitwise logic or a single-position shift. The result lands in an output register. A four-bit operation code and a carry input choose the operation. The upper two code bits pick the section: arithmetic, logic, right shift or left shift. In the arithmetic and logic sections the lower two bits refine the choice.

Every arithmetic operation comes from one adder. The adder sums `a`, a second term and the carry input. The second term is `b`, the inverse of `b`, all zeros or all ones. That single structure gives transfer, add, add with carry, subtract with borrow, subtract, increment and decrement. The carry leaving the top adder stage is kept in a register of its own, next to the result.

A controller drives `op_sel`, `carry_in` and the operands, and raises `load_en` in each cycle whose outcome should be kept. The registers change only on a rising edge with `load_en` high.

The reset input `rst_n` asserts at once and is released in step with the clock. The registers stay cleared for two further rising edges after `rst_n` rises.

Top module: `alu_shift_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `carry_out` are 0. They stay 0 for two rising edges after `rst_n` goes high.
- R2: On a rising edge with `load_en` low, `result` and `carry_out` keep their values, whatever the other inputs are.
- R3: With `op_sel[3:2]` = 00, `result` becomes (a + T + carry_in) mod 2^WIDTH, where T is chosen by `op_sel[1:0]`: 00 gives b, 01 gives ~b, 10 gives all zeros, 11 gives all ones.
- R4: With `op_sel[3:2]` = 00, `carry_out` becomes bit WIDTH of the (WIDTH+1)-bit sum a + T + carry_in.
- R5: With `op_sel[3:2]` other than 00, `carry_out` keeps its value on a loading edge.
- R6: With `op_sel[3:2]` = 01, `result` becomes a & b, a | b, a ^ b or ~a for `op_sel[1:0]` = 00, 01, 10, 11 in turn. `carry_in` has no effect.
- R7: With `op_sel[3:2]` = 10, `result` becomes `a` shifted right by one place, with 0 entering the most significant bit. `op_sel[1:0]` and `carry_in` have no effect.
- R8: With `op_sel[3:2]` = 11, `result` becomes `a` shifted left by one place, with 0 entering bit 0. `op_sel[1:0]` and `carry_in` have no effect.
- R9: Decrementing 0 (code 0011, carry_in 0) gives all ones with carry 0. Incrementing all ones (code 0010, carry_in 1) gives 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en | input | 1 | Allows the registers to load on this edge |
| op_sel | input | 4 | Operation code: section in [3:2], function in [1:0] |
| carry_in | input | 1 | Carry into the adder |
| a | input | WIDTH | First operand; the operand that is shifted |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry from the top adder stage |

## Verification
The assertions check the following on every loading edge: the hold when `load_en` is low, the carry hold outside the arithmetic section, the zero fill and value of both shifts, the complement-A result, and the cleared state after reset. The bench's scenarios are needed for the full arithmetic results and their carries, chosen by the four-way term mux and the carry input. The same goes for the wrap-around cases at zero and all ones. Those values are compared against a reference model in the bench, over random and directed operand pairs.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  // Section select carried in op_sel[3:2]; the encoding is part of the interface.
  typedef enum logic [1:0] {
    SEC_ARITH = 2'b00,
    SEC_LOGIC = 2'b01,
    SEC_SHR   = 2'b10,
    SEC_SHL   = 2'b11
  } section_e;

  // Second adder term, op_sel[1:0] inside the arithmetic section.
  typedef enum logic [1:0] {
    TERM_B     = 2'b00,
    TERM_B_INV = 2'b01,
    TERM_ZERO  = 2'b10,
    TERM_ONES  = 2'b11
  } term_e;

  // Bitwise function, op_sel[1:0] inside the logic section.
  typedef enum logic [1:0] {
    LOG_AND   = 2'b00,
    LOG_OR    = 2'b01,
    LOG_XOR   = 2'b10,
    LOG_NOT_A = 2'b11
  } logic_fn_e;

endpackage

// File: rtl/alu_reset_sync.sv
module alu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/alu_arith_path.sv
module alu_arith_path
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       term_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] term;
  logic [SUM_W-1:0] full_sum;

  // Every arithmetic operation uses this one mux and one adder.
  always_comb begin
    unique case (term_e'(term_sel))
      TERM_B:     term = b;
      TERM_B_INV: term = ~b;
      TERM_ZERO:  term = '0;
      default:    term = '1;
    endcase
  end

  always_comb begin
    full_sum = {1'b0, a} + {1'b0, term} + {{WIDTH{1'b0}}, carry_in};
  end

  assign sum   = full_sum[WIDTH-1:0];
  assign carry = full_sum[SUM_W-1];

endmodule

// File: rtl/alu_logic_path.sv
module alu_logic_path
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn_sel,
  output logic [WIDTH-1:0] y
);

  // One four-input mux per bit, the same for every bit position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (logic_fn_e'(fn_sel))
        LOG_AND: y[i] = a[i] & b[i];
        LOG_OR:  y[i] = a[i] | b[i];
        LOG_XOR: y[i] = a[i] ^ b[i];
        default: y[i] = ~a[i];
      endcase
    end
  end

endmodule

// File: rtl/alu_shift_path.sv
module alu_shift_path #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] shr,
  output logic [WIDTH-1:0] shl
);

  // Logical shifts by one place; the vacated bit always takes 0.
  assign shr = {1'b0, a[WIDTH-1:1]};
  assign shl = {a[WIDTH-2:0], 1'b0};

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [3:0]       op_sel,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int SYNC_STAGES = 2;

  logic             rst_core_n;
  section_e         section;
  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] shr_y;
  logic [WIDTH-1:0] shl_y;

  logic [WIDTH-1:0] result_q, result_d;
  logic             carry_q,  carry_d;
  logic             result_ld, carry_ld;

  alu_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign section = section_e'(op_sel[3:2]);

  alu_arith_path #(.WIDTH(WIDTH)) u_arith (
    .a        (a),
    .b        (b),
    .term_sel (op_sel[1:0]),
    .carry_in (carry_in),
    .sum      (arith_y),
    .carry    (arith_c)
  );

  alu_logic_path #(.WIDTH(WIDTH)) u_logic (
    .a      (a),
    .b      (b),
    .fn_sel (op_sel[1:0]),
    .y      (logic_y)
  );

  alu_shift_path #(.WIDTH(WIDTH)) u_shift (
    .a   (a),
    .shr (shr_y),
    .shl (shl_y)
  );

  // Next-state selection.
  always_comb begin
    unique case (section)
      SEC_ARITH: result_d = arith_y;
      SEC_LOGIC: result_d = logic_y;
      SEC_SHR:   result_d = shr_y;
      default:   result_d = shl_y;
    endcase
    carry_d   = arith_c;
    result_ld = load_en;
    carry_ld  = load_en && (section == SEC_ARITH);
  end

  // Registers with explicit clock enables.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      result_q <= '0;
    end else if (result_ld) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      carry_q <= 1'b0;
    end else if (carry_ld) begin
      carry_q <= carry_d;
    end
  end

  assign result    = result_q;
  assign carry_out = carry_q;

endmodule

// File: rtl/alu_shift_unit_checker.sv
module alu_shift_unit_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_core_n,
  input logic             load_en,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);

  // R1: reset low clears both registers by the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && carry_out == 1'b0));

  // R2: no load, no change
  a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_core_n)
    !load_en |=> $stable(result));

  a_r2_hold_carry: assert property (@(posedge clk) disable iff (!rst_core_n)
    !load_en |=> $stable(carry_out));

  // R5: carry untouched outside the arithmetic section
  a_r5_carry_keep: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && op_sel[3:2] != 2'b00) |=> $stable(carry_out));

  // R6: complement of a
  a_r6_not_a: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && op_sel == 4'b0111) |=> (result == ~$past(a)));

  // R7: right shift fills the top with zero
  a_r7_shr_value: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && op_sel[3:2] == 2'b10) |=> (result == ($past(a) >> 1)));

  // R8: left shift fills bit 0 with zero
  a_r8_shl_value: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && op_sel[3:2] == 2'b11) |=> (result == ($past(a) << 1)));

endmodule

bind alu_shift_unit alu_shift_unit_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .load_en    (load_en),
  .op_sel     (op_sel),
  .a          (a),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/alu_shift_unit_bench.sv
module alu_shift_unit_bench;

  localparam int WIDTH      = 8;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_en;
  logic [3:0]       op_sel;
  logic             carry_in;
  logic [WIDTH-1:0] a, b;
  logic [WIDTH-1:0] result;
  logic             carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WIDTH-1:0] exp_res;
  logic             exp_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_shift_unit #(.WIDTH(WIDTH)) u_alu_shift_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .op_sel    (op_sel),
    .carry_in  (carry_in),
    .a         (a),
    .b         (b),
    .result    (result),
    .carry_out (carry_out)
  );

  // Reference: (WIDTH+1)-bit sum for the arithmetic section.
  function automatic logic [WIDTH:0] ref_sum(logic [1:0] t, logic ci,
                                             logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
    logic [WIDTH-1:0] term;
    case (t)
      2'b00:   term = y;
      2'b01:   term = ~y;
      2'b10:   term = '0;
      default: term = '1;
    endcase
    return {1'b0, x} + {1'b0, term} + (WIDTH+1)'(ci);
  endfunction

  function automatic logic [WIDTH-1:0] ref_result(logic [3:0] s, logic ci,
                                                  logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
    logic [WIDTH:0] f;
    f = ref_sum(s[1:0], ci, x, y);
    case (s[3:2])
      2'b00: return f[WIDTH-1:0];
      2'b01: case (s[1:0])
               2'b00:   return x & y;
               2'b01:   return x | y;
               2'b10:   return x ^ y;
               default: return ~x;
             endcase
      2'b10: return x >> 1;
      default: return x << 1;
    endcase
  endfunction

  function automatic string req_of(logic en, logic [3:0] s);
    if (!en) return "R2";
    case (s[3:2])
      2'b00: return "R3";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_res(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_c(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s carry_out actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge load, check at the next falling edge.
  task automatic apply(logic en, logic [3:0] s, logic ci,
                       logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, string tag);
    logic [WIDTH:0] f;
    load_en = en; op_sel = s; carry_in = ci; a = x; b = y;
    if (en) begin
      exp_res = ref_result(s, ci, x, y);
      if (s[3:2] == 2'b00) begin
        f = ref_sum(s[1:0], ci, x, y);
        exp_c = f[WIDTH];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_res(tag, result, exp_res);
    if (en && s[3:2] == 2'b00) check_c((tag == "R9") ? "R9" : "R4", carry_out, exp_c);
    else check_c((en) ? "R5" : "R2", carry_out, exp_c);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1F));
    rst_n = 1'b0; load_en = 1'b1; op_sel = 4'b0000; carry_in = 1'b1;
    a = 8'hA5; b = 8'h3C;
    exp_res = '0; exp_c = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: cleared while reset is held, even with load_en high
    check_res("R1", result, '0);
    check_c("R1", carry_out, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_res("R1", result, '0);
    @(posedge clk); @(negedge clk);
    check_res("R1", result, '0);
    check_c("R1", carry_out, 1'b0);

    // Directed arithmetic: all four terms, both carries (R3, R4)
    apply(1, 4'b0000, 0, 8'h70, 8'h25, "R3");
    apply(1, 4'b0000, 1, 8'hF0, 8'h20, "R3");
    apply(1, 4'b0001, 0, 8'h09, 8'h04, "R3");
    apply(1, 4'b0001, 1, 8'h05, 8'h03, "R3");
    apply(1, 4'b0001, 1, 8'h03, 8'h05, "R3");
    apply(1, 4'b0010, 0, 8'h5A, 8'hFF, "R3");
    apply(1, 4'b0011, 1, 8'h5A, 8'h00, "R3");
    // R9 wrap-around corners
    apply(1, 4'b0011, 0, 8'h00, 8'h12, "R9");
    apply(1, 4'b0010, 1, 8'hFF, 8'h34, "R9");
    // R5: carry is 1 now and must survive the other sections
    apply(1, 4'b0110, 1, 8'hC3, 8'h0F, "R6");
    apply(1, 4'b1001, 1, 8'h81, 8'h00, "R7");
    apply(1, 4'b1110, 0, 8'h81, 8'h00, "R8");
    // R6: all four functions, carry_in toggled
    apply(1, 4'b0100, 0, 8'hCC, 8'hAA, "R6");
    apply(1, 4'b0101, 1, 8'hCC, 8'hAA, "R6");
    apply(1, 4'b0110, 0, 8'hCC, 8'hAA, "R6");
    apply(1, 4'b0111, 1, 8'hCC, 8'hAA, "R6");
    // R7 / R8 with ends set
    apply(1, 4'b1011, 1, 8'hFF, 8'h00, "R7");
    apply(1, 4'b1100, 1, 8'hFF, 8'h00, "R8");
    // R2: load disabled with busy inputs
    apply(0, 4'b0000, 1, 8'h11, 8'h22, "R2");
    apply(0, 4'b1100, 0, 8'h7E, 8'h00, "R2");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic en;
      logic [3:0] s;
      en = ($urandom % 8) != 0;
      s  = 4'($urandom);
      apply(en, s, 1'($urandom), WIDTH'($urandom), WIDTH'($urandom), req_of(en, s));
    end

    // R1: reset in mid-run clears a non-zero state
    apply(1, 4'b0000, 1, 8'hFF, 8'h00, "R3");
    rst_n = 1'b0;
    #1;
    check_res("R1", result, '0);
    check_c("R1", carry_out, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule